// File: doc/BRIEF.md
# BCD Calendar Clock with Alarm

This block keeps wall-clock time in packed BCD: seconds, minutes, hours (00-23), day of month, month (01-12) and a two-digit year (00-99). A single-cycle enable pulse from a slow oscillator domain, nominally 32768 per second, feeds a prescaler. Each time the prescaler completes a second, the calendar steps once, and carries pass from seconds through to the year. Month lengths are honoured, and every year divisible by four counts as a leap year.

Software reaches the block through a plain byte-wide register port. A write takes effect at the clock edge, and a read returns data combinationally for the address presented. The port has no handshake, so there is no back-pressure. A second set of six registers holds an alarm time. When the time reached by an update equals that alarm time, a sticky alarm flag is set. Four periodic event flags record second, minute, hour and day boundaries. A busy bit rises shortly before each update so that software can keep its accesses away from the carry. Two interrupt outputs are gated by separate enables.

Top module: `bcd_rtc_core`

## Requirements
- R1: Register map (byte address, upper bits only; address bits 1:0 ignored): seconds 0x00, minutes 0x04, hours 0x08, day 0x0C, month 0x10, year 0x14; alarm copies of the same six fields at 0x20-0x34; control 0x40 (bit 0 = run); status 0x44; interrupt enable 0x48 (bit 3 = alarm, bit 2 = timer). Any other address reads 0x00. After reset: time 00:00:00, day 01, month 01, year 00; all alarm fields 00; control, enables and status all zero.
- R2: While run is 1, the seconds field advances once for every TICKS_PER_SEC cycles in which `tick_en` is high. While run is 0, `tick_en` has no effect and the time holds.
- R3: The fields wrap in BCD: seconds 59 to 00 carries to minutes, minutes 59 to 00 carries to hours, hours 23 to 00 carries to day, the last day of a month goes to day 01 and carries to month, month 12 goes to 01 and carries to year, and year 99 goes to 00.
- R4: February has 29 days when the year value is divisible by four and 28 otherwise. April, June, September and November have 30 days. All other months have 31.
- R5: A write to a time field shows on a read in the next cycle. A write to seconds restarts the prescaler count at zero. A time write in the same cycle as a due update cancels that update.
- R6: Status bit 0 (busy) is high while running during the last BUSY_TICKS prescaler counts before an update. Status bit 1 mirrors run.
- R7: Status bits 2, 3, 4 and 5 are set by an update, by an update that wraps the seconds, by one that wraps the minutes, and by one that wraps the hours, respectively. Writing 1 to a bit clears it. A set in the same cycle as a clear wins.
- R8: Status bit 6 (alarm) is set in the cycle after an update when all six time fields equal the six alarm fields. It stays set until software writes 1 to it. A direct time write that makes the fields equal does not set it.
- R9: `irq_alarm` is high exactly while the alarm flag and alarm enable are both 1. `irq_timer` is a one-cycle pulse in the cycle after each update while the timer enable is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_en | input | 1 | One-cycle oscillator tick enable |
| reg_addr | input | 8 | Register byte address |
| reg_we | input | 1 | Write strobe |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for `reg_addr` |
| irq_alarm | output | 1 | Alarm interrupt level |
| irq_timer | output | 1 | Per-second interrupt pulse |

## Verification
The bench builds the block with TICKS_PER_SEC = 4 and BUSY_TICKS = 1. With these values a simulated second lasts four ticks, so midnight, month-end, leap-February and century-wrap carries all occur within a few hundred cycles, and busy occupies exactly one prescaler count. The tick input is also gapped, so the prescaler is exercised with idle cycles between ticks. Time writes are placed on and off update cycles to exercise prescaler restart and update cancellation.

// File: rtl/rtc_pkg.sv
package rtc_pkg;
  localparam int NFIELD = 6;
  typedef logic [NFIELD-1:0][7:0] rtc_fields_t;

  localparam logic [2:0] IDX_SEC  = 3'd0;
  localparam logic [2:0] IDX_MIN  = 3'd1;
  localparam logic [2:0] IDX_HOUR = 3'd2;
  localparam logic [2:0] IDX_DAY  = 3'd3;
  localparam logic [2:0] IDX_MON  = 3'd4;
  localparam logic [2:0] IDX_YEAR = 3'd5;

  // next BCD value, units wrap into tens
  function automatic logic [7:0] bcd_inc(input logic [7:0] v);
    if (v[3:0] == 4'd9) return {v[7:4] + 4'd1, 4'd0};
    return {v[7:4], v[3:0] + 4'd1};
  endfunction

  // final day of a month, in BCD
  function automatic logic [7:0] last_day(input logic [7:0] mon, input logic [7:0] yr);
    logic [6:0] ybin;
    ybin = 7'(yr[7:4]) * 7'd10 + 7'(yr[3:0]);
    case (mon)
      8'h02:                      return (ybin[1:0] == 2'b00) ? 8'h29 : 8'h28;
      8'h04, 8'h06, 8'h09, 8'h11: return 8'h30;
      default:                    return 8'h31;
    endcase
  endfunction
endpackage

// File: rtl/rtc_prescaler.sv
module rtc_prescaler #(
  parameter int TICKS_PER_SEC = 32768,
  parameter int BUSY_TICKS    = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic tick,
  input  logic restart,
  output logic sec_pulse,
  output logic busy
);
  localparam int CW = (TICKS_PER_SEC > 1) ? $clog2(TICKS_PER_SEC) : 1;
  localparam logic [CW-1:0] LAST_C  = CW'(TICKS_PER_SEC - 1);
  localparam logic [CW:0]   BSTART  = (CW+1)'(TICKS_PER_SEC - BUSY_TICKS);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             cnt <= '0;
    else if (restart)       cnt <= '0;
    else if (run && tick)   cnt <= (cnt == LAST_C) ? '0 : cnt + 1'b1;
  end

  assign sec_pulse = run && tick && (cnt == LAST_C);
  assign busy      = run && ({1'b0, cnt} >= BSTART);
endmodule

// File: rtl/rtc_calendar.sv
module rtc_calendar
  import rtc_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        step,
  input  logic        wr_en,
  input  logic [2:0]  wr_idx,
  input  logic [7:0]  wr_data,
  output rtc_fields_t tm,
  output logic        upd,
  output logic [3:0]  ev_pulse
);
  assign upd         = step && !wr_en;
  assign ev_pulse[0] = upd;
  assign ev_pulse[1] = upd && (tm[IDX_SEC] == 8'h59);
  assign ev_pulse[2] = ev_pulse[1] && (tm[IDX_MIN] == 8'h59);
  assign ev_pulse[3] = ev_pulse[2] && (tm[IDX_HOUR] == 8'h23);

  logic day_wrap, mon_wrap;
  assign day_wrap = tm[IDX_DAY] == last_day(tm[IDX_MON], tm[IDX_YEAR]);
  assign mon_wrap = tm[IDX_MON] == 8'h12;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tm <= {8'h00, 8'h01, 8'h01, 8'h00, 8'h00, 8'h00};
    end else if (wr_en) begin
      tm[wr_idx] <= wr_data;
    end else if (upd) begin
      tm[IDX_SEC] <= ev_pulse[1] ? 8'h00 : bcd_inc(tm[IDX_SEC]);
      if (ev_pulse[1]) tm[IDX_MIN]  <= ev_pulse[2] ? 8'h00 : bcd_inc(tm[IDX_MIN]);
      if (ev_pulse[2]) tm[IDX_HOUR] <= ev_pulse[3] ? 8'h00 : bcd_inc(tm[IDX_HOUR]);
      if (ev_pulse[3]) begin
        tm[IDX_DAY] <= day_wrap ? 8'h01 : bcd_inc(tm[IDX_DAY]);
        if (day_wrap) begin
          tm[IDX_MON] <= mon_wrap ? 8'h01 : bcd_inc(tm[IDX_MON]);
          if (mon_wrap)
            tm[IDX_YEAR] <= (tm[IDX_YEAR] == 8'h99) ? 8'h00 : bcd_inc(tm[IDX_YEAR]);
        end
      end
    end
  end
endmodule

// File: rtl/rtc_alarm.sv
module rtc_alarm
  import rtc_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic [2:0]  wr_idx,
  input  logic [7:0]  wr_data,
  input  rtc_fields_t tm,
  input  logic        upd,
  input  logic        clr,
  output rtc_fields_t al,
  output logic        flag
);
  logic              upd_d;
  logic [NFIELD-1:0] fld_eq;

  for (genvar i = 0; i < NFIELD; i++) begin : g_cmp
    assign fld_eq[i] = (al[i] == tm[i]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      al    <= '0;
      upd_d <= 1'b0;
      flag  <= 1'b0;
    end else begin
      if (wr_en) al[wr_idx] <= wr_data;
      upd_d <= upd;
      if (upd_d && (&fld_eq)) flag <= 1'b1;
      else if (clr)           flag <= 1'b0;
    end
  end
endmodule

// File: rtl/bcd_rtc_core.sv
module bcd_rtc_core
  import rtc_pkg::*;
#(
  parameter int TICKS_PER_SEC = 32768,
  parameter int BUSY_TICKS    = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick_en,
  input  logic [7:0] reg_addr,
  input  logic       reg_we,
  input  logic [7:0] reg_wdata,
  output logic [7:0] reg_rdata,
  output logic       irq_alarm,
  output logic       irq_timer
);
  localparam logic [5:0] W_CTRL = 6'h10;
  localparam logic [5:0] W_STAT = 6'h11;
  localparam logic [5:0] W_IEN  = 6'h12;

  logic [2:0]  fidx;
  logic        fld_ok, tm_sel, al_sel;
  logic        tm_we, al_we, ctrl_we, st_we, ien_we, alarm_clr, sec_clr;
  logic        run, ien_alarm, ien_timer, irq_t_q;
  logic        sec_pulse, busy, upd, alarm_flag;
  logic [3:0]  ev_pulse, ev_q;
  rtc_fields_t tm, al;

  assign fidx      = reg_addr[4:2];
  assign fld_ok    = fidx < 3'd6;
  assign tm_sel    = (reg_addr[7:5] == 3'd0) && fld_ok;
  assign al_sel    = (reg_addr[7:5] == 3'd1) && fld_ok;
  assign tm_we     = reg_we && tm_sel;
  assign al_we     = reg_we && al_sel;
  assign ctrl_we   = reg_we && (reg_addr[7:2] == W_CTRL);
  assign st_we     = reg_we && (reg_addr[7:2] == W_STAT);
  assign ien_we    = reg_we && (reg_addr[7:2] == W_IEN);
  assign alarm_clr = st_we && reg_wdata[6];
  assign sec_clr   = tm_we && (fidx == IDX_SEC);

  rtc_prescaler #(.TICKS_PER_SEC(TICKS_PER_SEC), .BUSY_TICKS(BUSY_TICKS)) u_pre (
    .clk(clk), .rst_n(rst_n), .run(run), .tick(tick_en), .restart(sec_clr),
    .sec_pulse(sec_pulse), .busy(busy)
  );

  rtc_calendar u_cal (
    .clk(clk), .rst_n(rst_n), .step(sec_pulse), .wr_en(tm_we), .wr_idx(fidx),
    .wr_data(reg_wdata), .tm(tm), .upd(upd), .ev_pulse(ev_pulse)
  );

  rtc_alarm u_alm (
    .clk(clk), .rst_n(rst_n), .wr_en(al_we), .wr_idx(fidx), .wr_data(reg_wdata),
    .tm(tm), .upd(upd), .clr(alarm_clr), .al(al), .flag(alarm_flag)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run       <= 1'b0;
      ien_alarm <= 1'b0;
      ien_timer <= 1'b0;
      ev_q      <= '0;
      irq_t_q   <= 1'b0;
    end else begin
      if (ctrl_we) run <= reg_wdata[0];
      if (ien_we) begin
        ien_alarm <= reg_wdata[3];
        ien_timer <= reg_wdata[2];
      end
      ev_q    <= ev_pulse | (ev_q & ~(st_we ? reg_wdata[5:2] : 4'h0));
      irq_t_q <= upd && ien_timer;
    end
  end

  always_comb begin
    reg_rdata = 8'h00;
    if (tm_sel)                        reg_rdata = tm[fidx];
    else if (al_sel)                   reg_rdata = al[fidx];
    else if (reg_addr[7:2] == W_CTRL)  reg_rdata = {7'd0, run};
    else if (reg_addr[7:2] == W_STAT)  reg_rdata = {1'b0, alarm_flag, ev_q, run, busy};
    else if (reg_addr[7:2] == W_IEN)   reg_rdata = {4'd0, ien_alarm, ien_timer, 2'd0};
  end

  assign irq_alarm = alarm_flag && ien_alarm;
  assign irq_timer = irq_t_q;
endmodule

// File: rtl/rtc_core_chk.sv
module rtc_core_chk
  import rtc_pkg::*;
#(
  parameter int BUSY_TICKS = 4
) (
  input logic        clk,
  input logic        rst_n,
  input logic        run,
  input logic        busy,
  input logic        sec_pulse,
  input logic        upd,
  input logic        tm_we,
  input rtc_fields_t tm,
  input logic        alarm_flag,
  input logic        alarm_clr,
  input logic        irq_timer
);
  // R6
  busy_needs_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> run);

  // R2
  frozen_time_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !tm_we) |=> $stable(tm));

  // R2
  second_moves_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sec_pulse && !tm_we) |=> (tm[0] != $past(tm[0])));

  // R8
  alarm_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (alarm_flag && !alarm_clr) |=> alarm_flag);

  // R8
  alarm_after_upd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(alarm_flag) |-> $past(upd, 2));

  // R9
  timer_after_upd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_timer |-> $past(upd));

  if (BUSY_TICKS > 0) begin : g_busy
    // R6
    busy_at_update_chk: assert property (@(posedge clk) disable iff (!rst_n)
      sec_pulse |-> busy);
  end
endmodule

bind bcd_rtc_core rtc_core_chk #(.BUSY_TICKS(BUSY_TICKS)) u_chk (
  .clk(clk), .rst_n(rst_n), .run(run), .busy(busy), .sec_pulse(sec_pulse),
  .upd(upd), .tm_we(tm_we), .tm(tm), .alarm_flag(alarm_flag),
  .alarm_clr(alarm_clr), .irq_timer(irq_timer)
);

// File: tb/sim_bcd_rtc_core.sv
module sim_bcd_rtc_core;
  localparam int TPS = 4;
  localparam int BT  = 1;

  logic       clk = 1'b0, rst_n = 1'b0, tick_en = 1'b0, reg_we = 1'b0;
  logic [7:0] reg_addr = 8'h00, reg_wdata = 8'h00;
  logic [7:0] reg_rdata;
  logic       irq_alarm, irq_timer;

  bcd_rtc_core #(.TICKS_PER_SEC(TPS), .BUSY_TICKS(BT)) u0 (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .reg_addr(reg_addr),
    .reg_we(reg_we), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .irq_alarm(irq_alarm), .irq_timer(irq_timer)
  );

  always #5 clk = ~clk;

  int    total = 0, bad = 0;
  string ph = "R1";

  // behavioural model: binary fields, idx 0 sec .. 5 year
  int       tv[6];
  bit [7:0] al[6];
  int       cnt;
  bit       run, ia, it, af, upd_d, irqt;
  bit [3:0] ev;

  function automatic bit [7:0] tobcd(int v);
    return 8'((v / 10) * 16 + (v % 10));
  endfunction
  function automatic int frombcd(bit [7:0] b);
    return int'(b[7:4]) * 10 + int'(b[3:0]);
  endfunction
  function automatic int mlen(int mo, int yr);
    if (mo == 2) return (yr % 4 == 0) ? 29 : 28;
    if (mo == 4 || mo == 6 || mo == 9 || mo == 11) return 30;
    return 31;
  endfunction

  function automatic bit [7:0] mread(bit [7:0] a);
    bit busy;
    busy = run && (cnt >= TPS - BT);
    if (a < 8'h18 && a[1:0] == 0) return tobcd(tv[a[4:2]]);
    if (a >= 8'h20 && a < 8'h38 && a[1:0] == 0) return al[a[4:2]];
    if (a == 8'h40) return {7'd0, run};
    if (a == 8'h44) return {1'b0, af, ev, run, busy};
    if (a == 8'h48) return {4'd0, ia, it, 2'd0};
    return 8'h00;
  endfunction

  function automatic string tagof(bit [7:0] a);
    if (a < 8'h18) return "R3";
    if (a < 8'h40) return "R1";
    if (a == 8'h44) return "R7";
    return "R1";
  endfunction

  task automatic chk(string tag, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s (%s) at %0t: actual=%0h expected=%0h", tag, ph, $time, act, exp);
    end
  endtask

  task automatic model_reset();
    tv = '{0, 0, 0, 1, 1, 0};
    for (int i = 0; i < 6; i++) al[i] = 8'h00;
    cnt = 0; run = 0; ia = 0; it = 0; af = 0; upd_d = 0; irqt = 0; ev = 0;
  endtask

  task automatic step(bit [7:0] a, bit w, bit [7:0] d, bit tk);
    bit tw, aw, pulse, upd, match, sw;
    bit [3:0] pev;
    tw = w && a[7:5] == 0 && a[4:2] < 6;
    aw = w && a[7:5] == 1 && a[4:2] < 6;
    sw = w && a == 8'h44;
    pulse = run && tk && (cnt == TPS - 1);
    upd = pulse && !tw;
    match = 1;
    for (int i = 0; i < 6; i++) if (tobcd(tv[i]) != al[i]) match = 0;
    if (upd_d && match) af = 1;
    else if (sw && d[6]) af = 0;
    pev[0] = upd;
    pev[1] = upd && tv[0] == 59;
    pev[2] = pev[1] && tv[1] == 59;
    pev[3] = pev[2] && tv[2] == 23;
    if (sw) ev = ev & ~d[5:2];
    ev = ev | pev;
    irqt = upd && it;
    upd_d = upd;
    if (tw && a[4:2] == 0) cnt = 0;
    else if (run && tk) cnt = pulse ? 0 : cnt + 1;
    if (tw) tv[a[4:2]] = frombcd(d);
    else if (upd) begin
      tv[0]++;
      if (tv[0] == 60) begin
        tv[0] = 0; tv[1]++;
        if (tv[1] == 60) begin
          tv[1] = 0; tv[2]++;
          if (tv[2] == 24) begin
            tv[2] = 0; tv[3]++;
            if (tv[3] > mlen(tv[4], tv[5])) begin
              tv[3] = 1; tv[4]++;
              if (tv[4] > 12) begin tv[4] = 1; tv[5] = (tv[5] + 1) % 100; end
            end
          end
        end
      end
    end
    if (aw) al[a[4:2]] = d;
    if (w && a == 8'h40) run = d[0];
    if (w && a == 8'h48) begin ia = d[3]; it = d[2]; end
  endtask

  task automatic cyc(bit [7:0] a, bit w, bit [7:0] d, bit tk);
    @(negedge clk);
    reg_addr = a; reg_we = w; reg_wdata = d; tick_en = tk;
    #3;
    chk(tagof(a), reg_rdata, mread(a));
    chk("R9", irq_alarm, af && ia);
    chk("R9", irq_timer, irqt);
    @(posedge clk);
    step(a, w, d, tk);
  endtask

  bit [7:0] rot[10] = '{8'h00, 8'h44, 8'h04, 8'h08, 8'h44, 8'h0C, 8'h10, 8'h14, 8'h20, 8'h48};

  task automatic idle(int n, int gap);
    for (int i = 0; i < n; i++)
      cyc(rot[i % 10], 1'b0, 8'h00, (gap == 0) || (i % gap != 0));
  endtask

  task automatic wr(bit [7:0] a, bit [7:0] d);
    cyc(a, 1'b1, d, 1'b1);
  endtask

  task automatic set_time(bit [7:0] base, bit [7:0] y, bit [7:0] mo, bit [7:0] dd,
                          bit [7:0] h, bit [7:0] mi, bit [7:0] s);
    wr(base + 8'h14, y); wr(base + 8'h10, mo); wr(base + 8'h0C, dd);
    wr(base + 8'h08, h); wr(base + 8'h04, mi); wr(base, s);
  endtask

  bit done = 0;

  initial begin
    model_reset();
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    // R1 reset values, R2 ticks ignored while stopped
    ph = "R1";
    idle(12, 0);
    cyc(8'h60, 1'b0, 8'h00, 1'b1);
    cyc(8'h1C, 1'b0, 8'h00, 1'b1);
    cyc(8'h40, 1'b0, 8'h00, 1'b1);
    // R3 carries across midnight into March, alarm fires, R9 irqs
    ph = "R3";
    set_time(8'h00, 8'h23, 8'h02, 8'h28, 8'h23, 8'h59, 8'h50);
    set_time(8'h20, 8'h23, 8'h03, 8'h01, 8'h00, 8'h00, 8'h05);
    wr(8'h48, 8'h0C);
    wr(8'h40, 8'h01);
    idle(100, 0);
    // R8 clear alarm, R7 clear events
    ph = "R8";
    wr(8'h44, 8'h40);
    idle(6, 0);
    ph = "R7";
    wr(8'h44, 8'h3C);
    idle(12, 0);
    // R4 leap February, 30-day month, year wrap
    ph = "R4";
    wr(8'h40, 8'h00);
    set_time(8'h00, 8'h24, 8'h02, 8'h28, 8'h23, 8'h59, 8'h58);
    wr(8'h40, 8'h01);
    idle(20, 0);
    set_time(8'h00, 8'h24, 8'h02, 8'h29, 8'h23, 8'h59, 8'h59);
    idle(10, 0);
    set_time(8'h00, 8'h25, 8'h04, 8'h30, 8'h23, 8'h59, 8'h59);
    idle(10, 0);
    set_time(8'h00, 8'h99, 8'h12, 8'h31, 8'h23, 8'h59, 8'h59);
    idle(10, 0);
    // R5 seconds write restarts prescaler, writes on update cycles
    ph = "R5";
    for (int k = 0; k < 6; k++) begin
      idle(k + 1, 0);
      wr(8'h00, 8'h30);
      idle(3, 0);
      wr(8'h04, 8'h10);
    end
    // R6 busy with gapped ticks
    ph = "R6";
    idle(60, 3);
    // R8 direct write making fields equal leaves alarm clear
    ph = "R8";
    wr(8'h44, 8'h7C);
    wr(8'h40, 8'h00);
    set_time(8'h00, 8'h30, 8'h06, 8'h15, 8'h12, 8'h00, 8'h00);
    set_time(8'h20, 8'h30, 8'h06, 8'h15, 8'h12, 8'h00, 8'h00);
    idle(10, 0);
    // R2 stopped clock holds
    ph = "R2";
    idle(20, 0);
    wr(8'h40, 8'h01);
    idle(12, 2);
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #1000000;
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule